// File: doc/BRIEF.md
# LCD Module Hardware Reset Sequencer

This block produces the hardware reset waveform for a parallel-bus LCD module. When software issues a start pulse, the block captures three programmed lengths. It then drives the module's reset line through three phases. The line is first held at its released (high) level, then pulled low, then released high again. The first two phases are timed in 10 µs units. The third phase is timed in 100 µs units. Each time base comes from its own prescaler, which is sized from the reference clock frequency given in MHz.

When the third phase has run its course, the block raises a one-cycle done flag, and the pin stays at its released level. The command engine uses the done flag as its cue to begin issuing bus transactions. A length of zero removes its phase from the waveform altogether. A polarity input inverts the pin for boards that place an inverter on the reset line.

Top module: `lcm_rst_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0, and lcd_rst_o sits at its released level: logic 1 XOR rst_inv_i.
- R2: Consider a start accepted at clock edge E0. For the next len_hi1_i × FINE cycles, the logical pin level is high. FINE is 10 × REF_MHZ.
- R3: The low phase follows at once. The logical pin level is low for len_lo_i × FINE cycles.
- R4: The second high phase follows. The logical pin level is high for len_hi2_i × COARSE cycles. COARSE is 100 × REF_MHZ.
- R5: The prescaler terminal counts are exactly 10 × REF_MHZ cycles (phases 1 and 2) and 100 × REF_MHZ cycles (phase 3). Each prescaler restarts at the entry to its phase.
- R6: A phase length of zero removes that phase entirely. The length never wraps to a long count. With all three lengths zero, done follows the start by one cycle.
- R7: A start pulse has no effect while busy_o is 1. This includes the cycle in which done_o is 1.
- R8: done_o is 1 for exactly one cycle, in the cycle after the last phase ends. busy_o is 1 from the cycle after the start through that done cycle, and 0 afterwards. The pin then stays released.
- R9: rst_inv_i = 1 inverts lcd_rst_o in every state.
- R10: The three lengths are captured when the start is accepted. Changes to the length inputs during a sequence do not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to run the sequence |
| len_hi1_i | input | LEN_W | First high phase length, in 10 µs units |
| len_lo_i | input | LEN_W | Low phase length, in 10 µs units |
| len_hi2_i | input | LEN_W | Second high phase length, in 100 µs units |
| rst_inv_i | input | 1 | Invert the reset pin |
| lcd_rst_o | output | 1 | Reset pin to the LCD module |
| busy_o | output | 1 | Sequence in progress (includes the done cycle) |
| done_o | output | 1 | One-cycle completion flag |

## Verification
Two functions can meet in one cycle. A new start can arrive in the cycle in which the sequence signals done. A phase can end in the same cycle that the zero-length skip picks its successor. The bench drives a start pulse exactly on the done cycle and again in mid-phase. It judges that the pin, busy and done waveforms match the single-sequence timeline, and that no second sequence appears afterwards. It runs every zero-length placement (first, middle, last, all) and compares each cycle against the timeline computed from the remaining phases.

// File: rtl/lcm_rst_pkg.sv
package lcm_rst_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_HI1  = 3'd1,
      ST_LO   = 3'd2,
      ST_HI2  = 3'd3,
      ST_DONE = 3'd4
   } seq_st_e;
endpackage

// File: rtl/lcm_tick_div.sv
// Time-base prescaler: pulses tick_o every TERM enabled cycles, restarted by clr_i.
module lcm_tick_div #(
   parameter int TERM = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic tick_o
);
   localparam int CW = (TERM > 1) ? $clog2(TERM) : 1;
   localparam logic [CW-1:0] LAST = CW'(TERM - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (TERM < 2) begin : g_bad
         $error("lcm_tick_div: TERM must be at least 2");
      end
      if ((TERM & (TERM - 1)) == 0) begin : g_pow2
         // counter wraps naturally at the terminal value
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clr_i)  cnt_q <= '0;
            else if (en_i)   cnt_q <= cnt_q + CW'(1);
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clr_i)  cnt_q <= '0;
            else if (en_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
         end
      end
   endgenerate

   assign tick_o = en_i && (cnt_q == LAST);

   p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
   p_tick_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/lcm_unit_cnt.sv
// Counts prescaler ticks within one phase; flags the tick that completes it.
module lcm_unit_cnt #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         act_i,
   input  logic         tick_i,
   input  logic [W-1:0] len_i,
   output logic         last_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (tick_i)  cnt_q <= cnt_q + W'(1);
   end

   assign last_o = tick_i && (cnt_q == (len_i - W'(1)));

   p_unit_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i && len_i != '0) |-> (cnt_q < len_i));
endmodule

// File: rtl/lcm_rst_seq.sv
module lcm_rst_seq #(
   parameter int REF_MHZ   = 200,
   parameter int LEN_W     = 11,
   parameter int FINE_US   = 10,
   parameter int COARSE_US = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LEN_W-1:0] len_hi1_i,
   input  logic [LEN_W-1:0] len_lo_i,
   input  logic [LEN_W-1:0] len_hi2_i,
   input  logic             rst_inv_i,
   output logic             lcd_rst_o,
   output logic             busy_o,
   output logic             done_o
);
   import lcm_rst_pkg::*;

   localparam int FINE_TERM   = FINE_US * REF_MHZ;
   localparam int COARSE_TERM = COARSE_US * REF_MHZ;

   generate
      if (REF_MHZ < 1) begin : g_chk_ref
         $error("lcm_rst_seq: REF_MHZ must be positive");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_chk_len
         $error("lcm_rst_seq: LEN_W out of range");
      end
      if (FINE_US < 1 || COARSE_US < 1) begin : g_chk_unit
         $error("lcm_rst_seq: unit lengths must be positive");
      end
   endgenerate

   seq_st_e          state_q, state_d;
   logic [LEN_W-1:0] l1_q, l2_q, l3_q;
   logic             accept, restart;
   logic             fine_en, coarse_en, fine_tick, coarse_tick;
   logic             unit_last;
   logic [LEN_W-1:0] len_sel;

   assign accept = start_i && (state_q == ST_IDLE);

   // length capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l1_q <= '0;
         l2_q <= '0;
         l3_q <= '0;
      end else if (accept) begin
         l1_q <= len_hi1_i;
         l2_q <= len_lo_i;
         l3_q <= len_hi2_i;
      end
   end

   // phase sequencing with zero-length skip
   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (start_i) begin
            if      (len_hi1_i != '0) state_d = ST_HI1;
            else if (len_lo_i  != '0) state_d = ST_LO;
            else if (len_hi2_i != '0) state_d = ST_HI2;
            else                      state_d = ST_DONE;
         end
         ST_HI1: if (unit_last) begin
            if      (l2_q != '0) state_d = ST_LO;
            else if (l3_q != '0) state_d = ST_HI2;
            else                 state_d = ST_DONE;
         end
         ST_LO: if (unit_last) begin
            if (l3_q != '0) state_d = ST_HI2;
            else            state_d = ST_DONE;
         end
         ST_HI2:  if (unit_last) state_d = ST_DONE;
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign restart   = (state_d != state_q);
   assign fine_en   = (state_q == ST_HI1) || (state_q == ST_LO);
   assign coarse_en = (state_q == ST_HI2);

   always_comb begin
      case (state_q)
         ST_HI1:  len_sel = l1_q;
         ST_LO:   len_sel = l2_q;
         ST_HI2:  len_sel = l3_q;
         default: len_sel = '0;
      endcase
   end

   lcm_tick_div #(.TERM(FINE_TERM)) u_fine_div (
      .clk(clk), .rst_n(rst_n), .clr_i(restart), .en_i(fine_en), .tick_o(fine_tick)
   );

   lcm_tick_div #(.TERM(COARSE_TERM)) u_coarse_div (
      .clk(clk), .rst_n(rst_n), .clr_i(restart), .en_i(coarse_en), .tick_o(coarse_tick)
   );

   lcm_unit_cnt #(.W(LEN_W)) u_units (
      .clk(clk), .rst_n(rst_n), .clr_i(restart), .act_i(fine_en | coarse_en),
      .tick_i(fine_tick | coarse_tick), .len_i(len_sel), .last_o(unit_last)
   );

   assign lcd_rst_o = (state_q != ST_LO) ^ rst_inv_i;
   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = (state_q == ST_DONE);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));
   p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(done_o));
   p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o && start_i && !unit_last) |=> (state_q == $past(state_q)));
   p_low_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == ST_LO) |-> $past(state_q == ST_HI1 || state_q == ST_IDLE));
   p_hi2_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(state_q == ST_HI2) |-> (state_q == ST_DONE));
   p_skip_hi1_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HI1) |-> (l1_q != '0));
   p_skip_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LO) |-> (l2_q != '0));
   p_skip_hi2_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HI2) |-> (l3_q != '0));
   p_len_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> ($stable(l1_q) && $stable(l2_q) && $stable(l3_q)));
endmodule

// File: tb/lcm_rst_seq_tb_top.sv
module lcm_rst_seq_tb_top;
   localparam int REF_MHZ = 2;
   localparam int LEN_W   = 11;
   localparam int FINE    = 10 * REF_MHZ;
   localparam int COARSE  = 100 * REF_MHZ;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [LEN_W-1:0] len_hi1_i = '0, len_lo_i = '0, len_hi2_i = '0;
   logic             rst_inv_i = 1'b0;
   logic             lcd_rst_o, busy_o, done_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   lcm_rst_seq #(.REF_MHZ(REF_MHZ), .LEN_W(LEN_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .len_hi1_i(len_hi1_i), .len_lo_i(len_lo_i), .len_hi2_i(len_hi2_i),
      .rst_inv_i(rst_inv_i), .lcd_rst_o(lcd_rst_o), .busy_o(busy_o), .done_o(done_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Runs one sequence and compares every cycle with the timeline from the lengths.
   // start_at / chg_at: cycle index at which an extra start or a length change is driven (-1 none).
   task automatic run_seq(input int l1, input int l2, input int l3, input bit inv,
                          input int start_at, input int chg_at, input string req);
      int a, b, c, tot;
      int bad_pin, bad_busy, bad_done;
      int fp_a, fp_e, fb_a, fb_e, fd_a, fd_e;
      a = l1 * FINE; b = l2 * FINE; c = l3 * COARSE; tot = a + b + c;
      bad_pin = 0; bad_busy = 0; bad_done = 0;
      fp_a = 0; fp_e = 0; fb_a = 0; fb_e = 0; fd_a = 0; fd_e = 0;
      @(negedge clk);
      len_hi1_i = LEN_W'(l1); len_lo_i = LEN_W'(l2); len_hi2_i = LEN_W'(l3);
      rst_inv_i = inv; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i <= tot + 4; i++) begin
         bit lvl, eb, ed, ep;
         lvl = !((i >= a) && (i < a + b));
         ep  = lvl ^ inv;
         eb  = (i <= tot);
         ed  = (i == tot);
         if (lcd_rst_o !== ep) begin
            if (bad_pin == 0) begin fp_a = int'(lcd_rst_o); fp_e = int'(ep); end
            bad_pin++;
         end
         if (busy_o !== eb) begin
            if (bad_busy == 0) begin fb_a = int'(busy_o); fb_e = int'(eb); end
            bad_busy++;
         end
         if (done_o !== ed) begin
            if (bad_done == 0) begin fd_a = int'(done_o); fd_e = int'(ed); end
            bad_done++;
         end
         start_i = (i == start_at);
         if (i == chg_at) begin
            len_hi1_i = LEN_W'(7); len_lo_i = LEN_W'(7); len_hi2_i = LEN_W'(7);
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      check(bad_pin == 0,  req, "pin waveform (first mismatch)",  fp_a, fp_e);
      check(bad_busy == 0, req, "busy waveform (first mismatch)", fb_a, fb_e);
      check(bad_done == 0, req, "done waveform (first mismatch)", fd_a, fd_e);
   endtask

   task automatic t_reset();
      // R1: released level, flags clear
      check(lcd_rst_o === 1'b1, "R1", "pin after reset", int'(lcd_rst_o), 1);
      check(busy_o === 1'b0, "R1", "busy after reset", int'(busy_o), 0);
      check(done_o === 1'b0, "R1", "done after reset", int'(done_o), 0);
   endtask

   task automatic t_basic();   run_seq(3, 2, 2, 1'b0, -1, -1, "R2/R3/R4/R5/R8"); endtask
   task automatic t_invert();  run_seq(1, 1, 1, 1'b1, -1, -1, "R9"); endtask
   task automatic t_skip_first();  run_seq(0, 2, 1, 1'b0, -1, -1, "R6 first zero"); endtask
   task automatic t_skip_middle(); run_seq(2, 0, 1, 1'b0, -1, -1, "R6 middle zero"); endtask
   task automatic t_skip_last();   run_seq(2, 1, 0, 1'b0, -1, -1, "R6 last zero"); endtask
   task automatic t_all_zero();    run_seq(0, 0, 0, 1'b0, -1, -1, "R6 all zero"); endtask
   task automatic t_busy_start();
      run_seq(2, 2, 1, 1'b0, 15, -1, "R7 mid-phase start");
      // 2*FINE + 2*FINE + 1*COARSE is the done cycle index
      run_seq(2, 2, 1, 1'b0, 4 * FINE + COARSE, -1, "R7 start on done");
   endtask
   task automatic t_latch();   run_seq(2, 2, 1, 1'b0, -1, 5, "R10"); endtask
   task automatic t_long();    run_seq(2047, 1, 1, 1'b0, -1, -1, "R2/R5 max length"); endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_basic();
      t_invert();
      t_skip_first();
      t_skip_middle();
      t_skip_last();
      t_all_zero();
      t_busy_start();
      t_latch();
      t_long();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule